// File: doc/BRIEF.md
# Two-Node Distributed Bus Arbiter

This block is the per-node arbitration logic for an external bus shared by up to two processor nodes and a host. Each node has an identical copy. A node drives one request line, the one its hard-wired ID selects, and watches all request lines. Every copy decides on its own which node is master. All copies see the same lines and apply the same rules, so they always agree. The node reports its own mastership on a registered bus-master output.

The current master keeps the bus until its own request drops. When the master hands over, the bus is idle for exactly one cycle before the next node takes it. A slave whose core needs the bus pulls a shared open-drain priority line. A master that is running only background DMA then gives the bus up. A lock input lets a master keep the bus through an indivisible read-modify-write. A host request makes an unlocked master release the bus, and no node is granted while it is present. A node whose ID marks a single-processor system is always master.

Top module: `bus_arb_node`

## Requirements
- R1: The ID is captured only while reset is high and is ignored afterwards. ID 1 gives the node request line index 0, ID 2 gives it request line index 1, and ID 0 or 3 gives the single-processor role.
- R2: The node drives only its own request level, `breq_out`. A node in the single-processor role never requests and never drives the priority line.
- R3: `is_master` is high in every cycle, including the first cycle after reset, when the node is in the single-processor role. Otherwise it is high only while the node owns the bus.
- R4: From an idle bus with no host request, a node whose core or DMA request rises is master two cycles later.
- R5: When both request lines are high on an idle bus, the node on request line index 0 wins.
- R6: The master keeps the bus while its request is up. After its request drops, the bus is idle for exactly one cycle and the other requester becomes master in the following cycle.
- R7: A slave with a core request drives the priority line one cycle later. A master with only a DMA request, and not locked, then drops its request. The master loses `is_master` three cycles after the slave's core request rises, and the slave is master one cycle after that. A master with a core request of its own is not preempted.
- R8: While `lock` is high, the master keeps the bus regardless of the priority line or the host request.
- R9: A host request makes an unlocked master drop its request. `is_master` falls two cycles later, no node is granted while the host request stays high, and requesting nodes regain the bus two cycles after it falls.
- R10: Under reset, `breq_out`, `cpa_drive` and, in the shared roles, `is_master` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; ID captured while high |
| node_id | input | 2 | Hard-wired node ID |
| core_req | input | 1 | Core of this node needs the bus |
| dma_req | input | 1 | Background DMA of this node needs the bus |
| lock | input | 1 | Hold mastership for an indivisible sequence |
| host_req | input | 1 | Host bus request, overrides both nodes |
| breq_in | input | 2 | Observed levels of all request lines, index 0 highest priority |
| breq_out | output | 1 | Level this node drives onto its own request line |
| cpa_in | input | 1 | Sensed level of the shared priority line (high = asserted) |
| cpa_drive | output | 1 | Enable for this node's open-drain pull on the priority line |
| is_master | output | 1 | Node currently owns the bus |

## Verification
Each result has a fixed latency counted in register stages. A request change reaches `breq_out` after one clock edge, and ownership follows at the next edge, so a grant from idle is due two cycles after the stimulus. A handover adds one idle cycle after the request drops. A preemption by the priority line adds one more stage for the slave's line pull, so the master's loss is due at cycle three and the slave's grant at cycle four. The bench stamps each expected result with the exact cycle number derived this way and compares it at the falling edge of that cycle, so a result that is one cycle early or late fails.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  typedef enum logic {
    ROLE_SHARED = 1'b0,
    ROLE_SOLO   = 1'b1
  } role_kind_t;

  // An ID of zero, or one above the node count, selects the single-processor role
  function automatic logic id_is_solo(input logic [7:0] id, input int unsigned nodes);
    return (id == 8'd0) || (32'(id) > nodes);
  endfunction

endpackage

// File: rtl/bus_arb_role.sv
module bus_arb_role
  import bus_arb_pkg::*;
#(
  parameter int unsigned NUM_NODES = 2,
  parameter int unsigned ID_W      = $clog2(NUM_NODES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ID_W-1:0] node_id,
  output role_kind_t      kind,
  output logic [ID_W-1:0] line_idx
);

  role_kind_t      kind_q;
  logic [ID_W-1:0] idx_q;

  // Capture the hard-wired ID only while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= id_is_solo(8'(node_id), NUM_NODES) ? ROLE_SOLO : ROLE_SHARED;
      idx_q  <= node_id;
    end
  end

  assign kind     = kind_q;
  assign line_idx = idx_q;

endmodule

// File: rtl/bus_arb_owner.sv
module bus_arb_owner #(
  parameter int unsigned NUM_NODES = 2,
  parameter int unsigned ID_W      = $clog2(NUM_NODES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_NODES-1:0] breq_in,
  input  logic                 host_req,
  output logic [ID_W-1:0]      owner_q,
  output logic [ID_W-1:0]      owner_d
);

  logic owner_holds;

  // Level of the current owner's request line (zero when idle)
  always_comb begin
    owner_holds = 1'b0;
    for (int i = 0; i < NUM_NODES; i++) begin
      if (owner_q == ID_W'(i + 1)) owner_holds = breq_in[i];
    end
  end

  // An owner whose line drops goes to idle first; the idle cycle is the changeover gap
  always_comb begin
    owner_d = owner_q;
    if (owner_q != '0) begin
      if (!owner_holds) owner_d = '0;
    end else if (!host_req) begin
      for (int i = NUM_NODES - 1; i >= 0; i--) begin
        if (breq_in[i]) owner_d = ID_W'(i + 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) owner_q <= '0;
    else     owner_q <= owner_d;
  end

endmodule

// File: rtl/bus_arb_reqdrv.sv
module bus_arb_reqdrv
  import bus_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  role_kind_t kind,
  input  logic       is_master,
  input  logic       core_req,
  input  logic       dma_req,
  input  logic       lock,
  input  logic       host_req,
  input  logic       cpa_in,
  output logic       breq_out,
  output logic       cpa_drive
);

  logic cpa_other;
  logic master_want;
  logic slave_want;
  logic yield_bus;
  logic breq_d;
  logic cpa_d;

  // Only a slave pulls the priority line, so a level not caused by this node comes from the other
  assign cpa_other   = cpa_in & ~cpa_drive;
  assign master_want = core_req | dma_req | lock;
  assign slave_want  = core_req | (dma_req & ~cpa_other);
  assign yield_bus   = ~lock & (host_req | (cpa_other & ~core_req));

  always_comb begin
    if (kind == ROLE_SOLO) begin
      breq_d = 1'b0;
      cpa_d  = 1'b0;
    end else if (is_master) begin
      breq_d = master_want & ~yield_bus;
      cpa_d  = 1'b0;
    end else begin
      breq_d = slave_want & ~host_req;
      cpa_d  = core_req;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      breq_out  <= 1'b0;
      cpa_drive <= 1'b0;
    end else begin
      breq_out  <= breq_d;
      cpa_drive <= cpa_d;
    end
  end

endmodule

// File: rtl/bus_arb_node.sv
module bus_arb_node
  import bus_arb_pkg::*;
#(
  parameter int unsigned NUM_NODES = 2,
  localparam int unsigned ID_W     = $clog2(NUM_NODES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ID_W-1:0]      node_id,
  input  logic                 core_req,
  input  logic                 dma_req,
  input  logic                 lock,
  input  logic                 host_req,
  input  logic [NUM_NODES-1:0] breq_in,
  output logic                 breq_out,
  input  logic                 cpa_in,
  output logic                 cpa_drive,
  output logic                 is_master
);

  role_kind_t      kind;
  logic [ID_W-1:0] line_idx;
  logic [ID_W-1:0] owner_q;
  logic [ID_W-1:0] owner_d;
  logic            role_solo;

  bus_arb_role #(.NUM_NODES(NUM_NODES), .ID_W(ID_W)) u_role (
    .clk      (clk),
    .rst      (rst),
    .node_id  (node_id),
    .kind     (kind),
    .line_idx (line_idx)
  );

  bus_arb_owner #(.NUM_NODES(NUM_NODES), .ID_W(ID_W)) u_owner (
    .clk      (clk),
    .rst      (rst),
    .breq_in  (breq_in),
    .host_req (host_req),
    .owner_q  (owner_q),
    .owner_d  (owner_d)
  );

  bus_arb_reqdrv u_reqdrv (
    .clk       (clk),
    .rst       (rst),
    .kind      (kind),
    .is_master (is_master),
    .core_req  (core_req),
    .dma_req   (dma_req),
    .lock      (lock),
    .host_req  (host_req),
    .cpa_in    (cpa_in),
    .breq_out  (breq_out),
    .cpa_drive (cpa_drive)
  );

  assign role_solo = (kind == ROLE_SOLO);

  // Registered mastership; a single-processor node is master straight out of reset
  always_ff @(posedge clk) begin
    if (rst) is_master <= id_is_solo(8'(node_id), NUM_NODES);
    else     is_master <= role_solo || (owner_d == line_idx);
  end

endmodule

// File: rtl/bus_arb_node_chk.sv
module bus_arb_node_chk (
  input logic clk,
  input logic rst,
  input logic solo,
  input logic is_master,
  input logic breq_out,
  input logic cpa_drive,
  input logic core_req,
  input logic lock,
  input logic host_req
);

  AST_SOLO_ALWAYS_MASTER: assert property (@(posedge clk) disable iff (rst)
    solo |-> is_master); // R3

  AST_SOLO_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    solo |-> (!breq_out && !cpa_drive)); // R2

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (!solo && $rose(is_master)) |-> $past(breq_out)); // R4

  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (rst)
    (!solo && is_master && $fell(breq_out)) |=> !is_master); // R6

  AST_CPA_FROM_SLAVE_CORE: assert property (@(posedge clk) disable iff (rst)
    cpa_drive |-> ($past(core_req) && !$past(is_master))); // R7

  AST_LOCK_KEEPS_REQ: assert property (@(posedge clk) disable iff (rst)
    (!solo && is_master && lock) |=> breq_out); // R8

  AST_HOST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!solo && is_master && host_req && !lock) |=> !breq_out); // R9

endmodule

bind bus_arb_node bus_arb_node_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .solo      (role_solo),
  .is_master (is_master),
  .breq_out  (breq_out),
  .cpa_drive (cpa_drive),
  .core_req  (core_req),
  .lock      (lock),
  .host_req  (host_req)
);

// File: tb/bus_arb_node_bench.sv
`timescale 1ns/1ps
module bus_arb_node_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [1:0] id_a, id_b, id_c;
  logic core_a, dma_a, lock_a, core_b, dma_b, lock_b, host;
  logic breq_a, breq_b, breq_c, cpa_a, cpa_b, cpa_c, cpa_line;
  logic mst_a, mst_b, mst_c;
  logic [1:0] lines;

  assign lines    = {breq_b, breq_a};
  assign cpa_line = cpa_a | cpa_b | cpa_c;

  bus_arb_node u_bus_arb_node (
    .clk(clk), .rst(rst), .node_id(id_a), .core_req(core_a), .dma_req(dma_a),
    .lock(lock_a), .host_req(host), .breq_in(lines), .breq_out(breq_a),
    .cpa_in(cpa_line), .cpa_drive(cpa_a), .is_master(mst_a));

  bus_arb_node u_node_b (
    .clk(clk), .rst(rst), .node_id(id_b), .core_req(core_b), .dma_req(dma_b),
    .lock(lock_b), .host_req(host), .breq_in(lines), .breq_out(breq_b),
    .cpa_in(cpa_line), .cpa_drive(cpa_b), .is_master(mst_b));

  bus_arb_node u_node_c (
    .clk(clk), .rst(rst), .node_id(id_c), .core_req(1'b1), .dma_req(1'b1),
    .lock(1'b0), .host_req(host), .breq_in(lines), .breq_out(breq_c),
    .cpa_in(cpa_line), .cpa_drive(cpa_c), .is_master(mst_c));

  typedef struct {
    int    cyc;
    logic  a;
    logic  b;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;

  task automatic expect_at(input int k, input logic a, input logic b, input string tag);
    q.push_back('{cyc + k, a, b, tag});
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  // Monitor: compare every expected item in the cycle it is due
  always @(negedge clk) begin
    cyc = cyc + 1;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks = checks + 1;
      if (e.cyc != cyc || mst_a !== e.a || mst_b !== e.b) begin
        fails = fails + 1;
        $display("FAIL %s cyc %0d: master a/b = %b/%b, expected %b/%b", e.tag, cyc,
                 mst_a, mst_b, e.a, e.b);
      end
      // R3 R2: the single-processor node stays master and never requests
      checks = checks + 1;
      if (mst_c !== 1'b1 || breq_c !== 1'b0 || cpa_c !== 1'b0) begin
        fails = fails + 1;
        $display("FAIL R3 cyc %0d: solo master/breq/cpa = %b/%b/%b, expected 1/0/0", cyc,
                 mst_c, breq_c, cpa_c);
      end
    end
    if (cyc > 4000) begin
      fails = fails + 1;
      $display("FAIL watchdog: cycle %0d, expected finish before 4000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    id_a = 2'b01; id_b = 2'b10; id_c = 2'b00;
    {core_a, dma_a, lock_a, core_b, dma_b, lock_b, host} = '0;
    wait_cyc(3);
    // R10: reset state
    checks = checks + 1;
    if (mst_a !== 1'b0 || mst_b !== 1'b0 || breq_a !== 1'b0 || cpa_a !== 1'b0 || mst_c !== 1'b1) begin
      fails = fails + 1;
      $display("FAIL R10: a/b/c master %b/%b/%b breq %b cpa %b, expected 0/0/1 0 0",
               mst_a, mst_b, mst_c, breq_a, cpa_a);
    end
    rst = 1'b0;
    // R1: IDs change after reset and must be ignored
    id_a = 2'b11; id_b = 2'b00; id_c = 2'b01;
    expect_at(1, 0, 0, "R10");
    wait_cyc(2);

    // R5 R4: both request from idle, line index 0 wins after two cycles
    core_a = 1; core_b = 1;
    expect_at(1, 0, 0, "R4");
    expect_at(2, 1, 0, "R5");
    wait_cyc(4);
    // R6: handover with one idle cycle
    core_a = 0;
    expect_at(2, 0, 0, "R6");
    expect_at(3, 0, 1, "R6");
    wait_cyc(4);
    core_b = 0;
    expect_at(3, 0, 0, "R6");
    wait_cyc(4);

    // R4: single requester
    core_b = 1;
    expect_at(2, 0, 1, "R4");
    wait_cyc(3);
    core_b = 0;
    wait_cyc(4);

    // R7: priority line preempts DMA-only master
    dma_a = 1;
    expect_at(2, 1, 0, "R4");
    wait_cyc(4);
    core_b = 1;
    expect_at(2, 1, 0, "R7");
    expect_at(3, 0, 0, "R7");
    expect_at(4, 0, 1, "R7");
    wait_cyc(7);
    core_b = 0;
    expect_at(2, 0, 0, "R6");
    expect_at(3, 1, 0, "R6");
    wait_cyc(4);
    dma_a = 0;
    wait_cyc(4);

    // R7: a master with a core request is not preempted
    core_a = 1; dma_a = 1;
    wait_cyc(4);
    core_b = 1;
    expect_at(4, 1, 0, "R7");
    wait_cyc(6);
    core_a = 0; dma_a = 0;
    expect_at(3, 0, 1, "R6");
    wait_cyc(4);
    core_b = 0;
    wait_cyc(4);

    // R8: lock holds against priority line and host
    dma_a = 1; lock_a = 1;
    expect_at(2, 1, 0, "R8");
    wait_cyc(3);
    core_b = 1;
    expect_at(4, 1, 0, "R8");
    wait_cyc(5);
    host = 1;
    expect_at(2, 1, 0, "R8");
    wait_cyc(3);
    // R9: lock released under host request
    lock_a = 0;
    expect_at(2, 0, 0, "R9");
    expect_at(4, 0, 0, "R9");
    wait_cyc(5);
    host = 0;
    expect_at(2, 0, 1, "R9");
    wait_cyc(3);
    core_b = 0; dma_a = 0;
    wait_cyc(4);

    // R9: host request on unlocked master, then regrant
    core_a = 1;
    expect_at(2, 1, 0, "R9");
    wait_cyc(3);
    host = 1;
    expect_at(2, 0, 0, "R9");
    wait_cyc(4);
    host = 0;
    expect_at(2, 1, 0, "R9");
    wait_cyc(3);
    core_a = 0;
    expect_at(3, 0, 0, "R6");
    wait_cyc(4);

    while (q.size() > 0) wait_cyc(1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule